// File: doc/BRIEF.md
# Gated-Clock Bit Serializer

This block turns an 8-bit parallel word into a bit-serial stream on two wires: a serial clock and a serial data line. A divider inside the block runs all the time and makes a base clock from the system clock. Two rate-select inputs set the divide ratio. The serial clock is that base clock ANDed with a transmit enable. The enable can change only on a base-clock rising edge, so it always opens and closes on whole pulses.

A start strobe seen while the block is idle latches the input word. The block then waits for the next base rising edge and opens the gate. A bit index drives a multiplexer that places one bit of the latched word on the data line, least significant bit first. The index advances on each falling edge of the serial clock, so a receiver can sample data on every rising edge. After eight pulses the gate closes, a one-cycle done pulse is raised and the block returns to idle.

Top module: `bitser_tx`

## Requirements
- R1: While reset is asserted and right after it, sclk, sdata, busy and done are all 0.
- R2: A start strobe while idle latches din. Its bits appear on sdata least significant bit first, one bit per sclk pulse, and each bit is valid at the rising edge of its sclk pulse.
- R3: rate_sel sets the serial clock period. 00 gives 2 system clocks, 01 gives 4, 10 gives 8 and 11 gives 16. Each high phase and each low phase between pulses lasts half that period.
- R4: The gate never produces a short pulse. The first and the last sclk high phases are as long as every other high phase, because the enable only changes together with a base-clock edge.
- R5: sdata changes only while sclk is low. It holds its value for the whole sclk high phase.
- R6: Each transfer gives exactly 8 sclk pulses. done is high for exactly one cycle, in the cycle in which sclk falls after the eighth pulse. In that same cycle busy is already 0.
- R7: While busy, changes on din and further start strobes have no effect. The word being sent stays intact, and no extra transfer follows.
- R8: busy rises in the cycle after an accepted start strobe. Without a start strobe, sclk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transfer request, accepted only while idle |
| rate_sel | input | 2 | Serial clock rate select (divide by 2, 4, 8, 16); hold stable during a transfer |
| din | input | 8 | Parallel word to send |
| sclk | output | 1 | Gated serial clock |
| sdata | output | 1 | Serial data, LSB first, valid on sclk rising edge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |

## Verification
busy is due one cycle after the edge that samples start. The first sclk rise follows at the next base-clock rising edge. done is due in exactly the cycle in which sclk falls after the eighth pulse.

The bench samples every output once per cycle on the falling system clock edge. It rebuilds each pulse from consecutive samples and counts the high and low samples against the half period chosen by rate_sel. It captures sdata at each rise, and it requires done to appear in the same sample as the final falling sclk and nowhere else.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/bitser_rate_div.sv
// Free-running base clock generator; half period is 2**rate system clocks.
module bitser_rate_div #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              base,
    output logic              rise_tick,
    output logic              fall_tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             base;
    } div_t;

    div_t d_d, d_q;
    logic [CNT_W:0] lim;
    logic           tick;

    always_comb begin
        lim  = ({{CNT_W{1'b0}}, 1'b1} << rate) - 1'b1;
        tick = ({1'b0, d_q.cnt} >= lim);
        d_d  = d_q;
        if (tick) begin
            d_d.cnt  = '0;
            d_d.base = ~d_q.base;
        end else begin
            d_d.cnt  = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign base      = d_q.base;
    assign rise_tick = tick & ~d_q.base;
    assign fall_tick = tick & d_q.base;

endmodule

// File: rtl/bitser_clk_gate.sv
// Enable register that only changes together with a base clock edge.
module bitser_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic base,
    input  logic rise_tick,
    input  logic fall_tick,
    input  logic arm,
    input  logic last,
    output logic sclk,
    output logic shift_evt
);
    typedef struct packed {
        logic en;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!g_q.en) begin
            g_d.en = arm & rise_tick;
        end else if (fall_tick && last) begin
            g_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk      = base & g_q.en;
    assign shift_evt = g_q.en & fall_tick;

    AST_EN_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.en) |-> base); // R4
    AST_EN_CLOSES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(g_q.en) |-> !base); // R4

endmodule

// File: rtl/bitser_bit_mux.sv
// Picks one bit of the latched word with a one-hot AND-OR tree.
module bitser_bit_mux #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  logic [IDX_W-1:0] idx,
    input  logic             active,
    output logic             bit_out
);
    logic [WIDTH-1:0] hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign hit[i] = (idx == IDX_W'(i)) & word[i];
    end

    assign bit_out = active & (|hit);

endmodule

// File: rtl/bitser_tx.sv
module bitser_tx
    import bitser_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [WIDTH-1:0]  din,
    output logic              sclk,
    output logic              sdata,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(WIDTH);

    typedef struct packed {
        tx_state_e        state;
        logic [WIDTH-1:0] word;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic base, rise_tick, fall_tick, shift_evt, last;

    bitser_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (rate_sel),
        .base      (base),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign last = (c_q.idx == IDX_W'(WIDTH - 1));

    bitser_clk_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (base),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .arm       (c_q.state == ST_ARM),
        .last      (last),
        .sclk      (sclk),
        .shift_evt (shift_evt)
    );

    bitser_bit_mux #(.WIDTH(WIDTH)) u_mux (
        .word    (c_q.word),
        .idx     (c_q.idx),
        .active  (c_q.state != ST_IDLE),
        .bit_out (sdata)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.word  = din;
                    c_d.idx   = '0;
                    c_d.state = ST_ARM;
                end
            end
            ST_ARM: begin
                if (rise_tick) c_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (shift_evt) begin
                    if (last) begin
                        c_d.state = ST_IDLE;
                        c_d.idx   = '0;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.state != ST_IDLE);
    assign done = c_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sclk)); // R6
    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk) && sclk) |-> $stable(sdata)); // R5
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(c_q.word)); // R7

endmodule

// File: tb/bitser_tx_bench.sv
module bitser_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [7:0] din = 8'h00;
    logic       sclk, sdata, busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bitser_tx u_bitser_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rate_sel (rate_sel),
        .din      (din),
        .sclk     (sclk),
        .sdata    (sdata),
        .busy     (busy),
        .done     (done)
    );

    // {rate_sel, din, disturb}
    localparam logic [10:0] VEC [0:7] = '{
        {2'd0, 8'hA5, 1'b0},
        {2'd1, 8'h3C, 1'b0},
        {2'd2, 8'h81, 1'b0},
        {2'd3, 8'h5A, 1'b0},
        {2'd0, 8'hFF, 1'b1},
        {2'd1, 8'h00, 1'b1},
        {2'd3, 8'h96, 1'b1},
        {2'd2, 8'h01, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [1:0] r, input logic [7:0] w, input bit disturb);
        int half = 1 << r;
        logic [7:0] got = 8'h00;
        int rises = 0, hi = 0, lo = 0;
        bit prev = 1'b0, cur = 1'b0, seen_done = 1'b0;
        bit width_ok = 1'b1, stable_ok = 1'b1, done_stray = 1'b0;
        int bad_w = 0;
        rate_sel = r;
        din = w;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        for (int c = 0; c < 400 && !seen_done; c++) begin
            if (disturb && c == 3) begin din = ~w; start = 1'b1; end
            if (disturb && c == 4) start = 1'b0;
            @(negedge clk);
            if (sclk && !prev) begin
                rises++;
                cur = sdata;
                if (rises <= 8) got[rises-1] = sdata;
                if (rises > 1 && lo != half) begin width_ok = 1'b0; bad_w = lo; end
                hi = 1;
            end else if (sclk && prev) begin
                hi++;
                if (sdata != cur) stable_ok = 1'b0;
            end else if (!sclk && prev) begin
                if (hi != half) begin width_ok = 1'b0; bad_w = hi; end
                lo = 1;
                if (done) begin
                    if (rises == 8) seen_done = 1'b1;
                    else done_stray = 1'b1;
                end
            end else begin
                lo++;
                if (done) done_stray = 1'b1;
            end
            if (done && !sclk && prev && rises == 8)
                chk(busy == 1'b0, "R6", "busy with done", int'(busy), 0);
            prev = sclk;
        end
        chk(seen_done, "R6", "done at final sclk fall", int'(seen_done), 1);
        chk(!done_stray, "R6", "done outside final fall", int'(done_stray), 0);
        chk(rises == 8, "R6", "pulse count", rises, 8);
        chk(got == w, disturb ? "R7" : "R2", "received word", int'(got), int'(w));
        chk(width_ok, r == 2'd0 ? "R4" : "R3", "phase length", bad_w, half);
        chk(stable_ok, "R5", "sdata steady while sclk high", int'(stable_ok), 1);
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", int'(done), 0);
        if (disturb) begin
            bit extra = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (sclk || busy) extra = 1'b1;
            end
            chk(!extra, "R7", "no transfer from ignored start", int'(extra), 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({sclk, sdata, busy, done} == 4'b0000, "R1", "outputs in reset",
            int'({sclk, sdata, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sclk, sdata, busy, done} == 4'b0000, "R1", "outputs after reset",
            int'({sclk, sdata, busy, done}), 0);

        for (int i = 0; i < 8; i++) begin
            run_xfer(VEC[i][10:9], VEC[i][8:1], VEC[i][0]);
        end

        // R8: idle with no start, sclk must stay low at every rate
        begin
            bit moved = 1'b0;
            for (int c = 0; c < 64; c++) begin
                rate_sel = 2'(c / 16);
                @(negedge clk);
                if (sclk || busy) moved = 1'b1;
            end
            chk(!moved, "R8", "sclk quiet without start", int'(moved), 0);
        end

        // R1: reset in the middle of a transfer clears everything
        rate_sel = 2'd3;
        din = 8'hC3;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({sclk, sdata, busy, done} == 4'b0000, "R1", "outputs after mid reset",
            int'({sclk, sdata, busy, done}), 0);
        rst_n = 1'b1;

        // R4: back-to-back start right after done, slowest and fastest rates
        run_xfer(2'd3, 8'h7E, 1'b0);
        run_xfer(2'd0, 8'h42, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule